// File: doc/BRIEF.md
# Three-Format RISC Decode and Execute Slice

This block is the decode, operand-read, execute and write-back portion of a small 32-bit load/store processor core. Every cycle it accepts one 32-bit instruction word qualified by a valid strobe. It splits the word into fields, reads up to two sources from a 32-entry by 32-bit general register file held inside the block, computes the result, and commits that result to the register file on the next rising clock edge. The instruction that follows therefore sees the new value at once.

The supported subset covers three register-register operations: add, subtract and signed set-less-than. It also covers the immediate operations add, signed set-less-than, AND and OR, and a load-upper-immediate that builds the top half of a constant. Each immediate form widens its 16-bit field in its own way.

The write-back value and destination index appear at the ports in the same cycle as the instruction. A word that decodes to nothing in the subset raises an illegal flag and leaves every register unchanged. Fetch, memory access, branches and shifts live in other blocks.

Top module: `insn_exec_slice`

## Requirements
- R1: After reset every general register reads as zero.
- R2: Opcode field instr[31:26] = 0 selects the register format, with sources instr[25:21] (first) and instr[20:16] (second) and destination instr[15:11]. Funct instr[5:0] = 32 adds the two sources modulo 2^32, with no overflow trap.
- R3: Register format with funct 34 writes first source minus second source, modulo 2^32.
- R4: Register format with funct 42 writes 1 when the first source is less than the second as signed two's complement values, and writes 0 otherwise.
- R5: Opcode 8 adds the source register instr[25:21] to the 16-bit field instr[15:0] with bit 15 copied into bits 31..16. The result goes to register instr[20:16], modulo 2^32.
- R6: Opcode 10 writes 1 when the source register is signed-less-than the sign-extended 16-bit field, and writes 0 otherwise.
- R7: Opcode 12 (AND) and opcode 13 (OR) combine the source register with the 16-bit field after zero-extension.
- R8: Opcode 15 writes the 16-bit field into bits 31..16 of the destination and zeros into bits 15..0.
- R9: Register 0 reads as zero at all times. An instruction aimed at it reports destination 0 and its computed data, but changes nothing.
- R10: Any other opcode, or opcode 0 with any other funct, raises `illegal`, drives `wb_data` and `wb_dst` to 0 and writes no register.
- R11: A result is committed at the rising edge that ends its cycle, so the next instruction reads the new value.
- R12: While `in_valid` is low, no register is written and `wb_data`, `wb_dst` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the register file |
| in_valid | input | 1 | Qualifies `instr` for this cycle |
| instr | input | 32 | Instruction word |
| wb_data | output | 32 | Result being written back this cycle |
| wb_dst | output | 5 | Destination register index this cycle |
| illegal | output | 1 | Instruction word not in the supported subset |

## Verification
The hardest situations to reach from the ports are those where the register file must hold a value the stimulus cannot write directly. Examples are a full 32-bit constant with the sign bit set, and a register that an illegal or idle cycle must leave untouched. The bench builds such values with chains of load-upper then OR, and reads any register back by adding it to register 0. A behavioural model tracks all 32 registers and compares every cycle. A long mixed stream then interleaves legal, illegal and idle cycles over random registers, so that back-to-back dependencies arise often.

// File: rtl/insn_exec_pkg.sv
package insn_exec_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 32;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int OPC_W    = 6;
    localparam int FUNCT_W  = 6;
    localparam int IMM_W    = 16;

    localparam logic [OPC_W-1:0]   OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0]   OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0]   OPC_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0]   OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0]   OPC_LUI   = 6'd15;

    localparam logic [FUNCT_W-1:0] FN_ADD    = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB    = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_SLT    = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_PASS_B
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN,
        EXT_ZERO,
        EXT_HIGH
    } imm_ext_e;

    typedef struct packed {
        logic              legal;
        alu_op_e           op;
        imm_ext_e          ext;
        logic              use_imm;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] dst;
    } dec_t;

endpackage

// File: rtl/insn_decoder.sv
module insn_decoder
    import insn_exec_pkg::*;
(
    input  logic [OPC_W-1:0]   opc,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [RIDX_W-1:0]  fld_s,
    input  logic [RIDX_W-1:0]  fld_t,
    input  logic [RIDX_W-1:0]  fld_d,
    output dec_t               dec
);

    always_comb begin
        dec         = '0;
        dec.op      = ALU_ADD;
        dec.ext     = EXT_SIGN;
        dec.src_a   = fld_s;
        dec.src_b   = fld_t;
        dec.dst     = fld_t;
        dec.use_imm = 1'b1;
        unique case (opc)
            OPC_REG: begin
                dec.use_imm = 1'b0;
                dec.dst     = fld_d;
                unique case (funct)
                    FN_ADD: begin dec.legal = 1'b1; dec.op = ALU_ADD; end
                    FN_SUB: begin dec.legal = 1'b1; dec.op = ALU_SUB; end
                    FN_SLT: begin dec.legal = 1'b1; dec.op = ALU_SLT; end
                    default: dec.legal = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                dec.legal = 1'b1;
                dec.op    = ALU_ADD;
                dec.ext   = EXT_SIGN;
            end
            OPC_SLTI: begin
                dec.legal = 1'b1;
                dec.op    = ALU_SLT;
                dec.ext   = EXT_SIGN;
            end
            OPC_ANDI: begin
                dec.legal = 1'b1;
                dec.op    = ALU_AND;
                dec.ext   = EXT_ZERO;
            end
            OPC_ORI: begin
                dec.legal = 1'b1;
                dec.op    = ALU_OR;
                dec.ext   = EXT_ZERO;
            end
            OPC_LUI: begin
                dec.legal = 1'b1;
                dec.op    = ALU_PASS_B;
                dec.ext   = EXT_HIGH;
            end
            default: dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import insn_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [RIDX_W-1:0] rb_idx,
    output logic [XLEN-1:0]   ra_data,
    output logic [XLEN-1:0]   rb_data,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data
);

    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    // index 0 is constant zero; entries 1..NREG-1 are storage
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_entry
            if (g == 0) begin : g_zero
                always_comb regs_d[g] = '0;
                always_ff @(posedge clk) regs_q[g] <= '0;
            end else begin : g_store
                always_comb begin
                    regs_d[g] = regs_q[g];
                    if (wr_en && (wr_idx == RIDX_W'(g)))
                        regs_d[g] = wr_data;
                end
                always_ff @(posedge clk) begin
                    if (!rst_n) regs_q[g] <= '0;
                    else        regs_q[g] <= regs_d[g];
                end
            end
        end
    endgenerate

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import insn_exec_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] sum_w;
    logic [XLEN-1:0] dif_w;
    logic            lt_w;

    always_comb begin
        sum_w = opa + opb;
        dif_w = opa - opb;
        lt_w  = $signed(opa) < $signed(opb);
        unique case (op)
            ALU_ADD:    res = sum_w;
            ALU_SUB:    res = dif_w;
            ALU_SLT:    res = {{(XLEN-1){1'b0}}, lt_w};
            ALU_AND:    res = opa & opb;
            ALU_OR:     res = opa | opb;
            ALU_PASS_B: res = opb;
            default:    res = '0;
        endcase
    end

endmodule

// File: rtl/insn_exec_slice.sv
module insn_exec_slice
    import insn_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    output logic [XLEN-1:0]   wb_data,
    output logic [RIDX_W-1:0] wb_dst,
    output logic              illegal
);

    localparam int FLD_S_LSB = 21;
    localparam int FLD_T_LSB = 16;
    localparam int FLD_D_LSB = 11;
    localparam int EXT_PAD   = XLEN - IMM_W;

    dec_t            dec_w;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_val;
    logic [XLEN-1:0] opb_val;
    logic [XLEN-1:0] alu_res;
    logic [IMM_W-1:0] imm_fld;

    typedef struct packed {
        logic              we;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   data;
        logic              bad;
    } wb_t;

    wb_t wb_d;

    assign imm_fld = instr[IMM_W-1:0];

    insn_decoder u_dec (
        .opc   (instr[31 -: OPC_W]),
        .funct (instr[FUNCT_W-1:0]),
        .fld_s (instr[FLD_S_LSB +: RIDX_W]),
        .fld_t (instr[FLD_T_LSB +: RIDX_W]),
        .fld_d (instr[FLD_D_LSB +: RIDX_W]),
        .dec   (dec_w)
    );

    always_comb begin
        unique case (dec_w.ext)
            EXT_SIGN: imm_val = {{EXT_PAD{imm_fld[IMM_W-1]}}, imm_fld};
            EXT_ZERO: imm_val = {{EXT_PAD{1'b0}}, imm_fld};
            EXT_HIGH: imm_val = {imm_fld, {EXT_PAD{1'b0}}};
            default:  imm_val = '0;
        endcase
        opb_val = dec_w.use_imm ? imm_val : rt_val;
    end

    exec_alu u_alu (
        .op  (dec_w.op),
        .opa (rs_val),
        .opb (opb_val),
        .res (alu_res)
    );

    always_comb begin
        wb_d      = '0;
        wb_d.bad  = in_valid && !dec_w.legal;
        if (in_valid && dec_w.legal) begin
            wb_d.we   = (dec_w.dst != '0);
            wb_d.dst  = dec_w.dst;
            wb_d.data = alu_res;
        end
    end

    gpr_file u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec_w.src_a),
        .rb_idx  (dec_w.src_b),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .wr_en   (wb_d.we),
        .wr_idx  (wb_d.dst),
        .wr_data (wb_d.data)
    );

    assign wb_data = wb_d.data;
    assign wb_dst  = wb_d.dst;
    assign illegal = wb_d.bad;

endmodule

// File: rtl/insn_exec_chk.sv
module insn_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] wb_data,
    input logic [4:0]  wb_dst,
    input logic        illegal
);

    logic is_reg;
    assign is_reg = in_valid && (instr[31:26] == 6'd0);

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (wb_data == 32'd0 && wb_dst == 5'd0)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!illegal && wb_dst == 5'd0 && wb_data == 32'd0)); // R12

    AST_LUI_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd15) |->
            (wb_data[15:0] == 16'd0 && wb_data[31:16] == instr[15:0] && !illegal)); // R8

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg && instr[5:0] == 6'd42) |-> (wb_data[31:1] == 31'd0)); // R4

    AST_SLTI_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd10) |-> (wb_data[31:1] == 31'd0)); // R6

    AST_ANDI_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd12) |-> (wb_data[31:16] == 16'd0)); // R7

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg && instr[5:0] == 6'd32 && instr[25:21] == 5'd0 && instr[20:16] == 5'd0)
            |-> (wb_data == 32'd0)); // R9

    AST_REG_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg && !illegal) |-> (wb_dst == instr[15:11])); // R2

endmodule

bind insn_exec_slice insn_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .instr    (instr),
    .wb_data  (wb_data),
    .wb_dst   (wb_dst),
    .illegal  (illegal)
);

// File: tb/insn_exec_slice_bench.sv
module insn_exec_slice_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = 32'd0;
    logic [31:0] wb_data;
    logic [4:0]  wb_dst;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_regs [32];

    always #10 clk = ~clk;

    insn_exec_slice u_insn_exec_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .instr    (instr),
        .wb_data  (wb_data),
        .wb_dst   (wb_dst),
        .illegal  (illegal)
    );

    function automatic logic [31:0] rtype(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] rd_reg(int k);
        return (k == 0) ? 32'd0 : model_regs[k];
    endfunction

    // behavioural reference: expected outputs for one cycle
    task automatic predict(input logic v, input logic [31:0] w,
                           output logic [31:0] d, output logic [4:0] dst, output logic ill);
        int op, fn, s, t, r;
        logic [31:0] a, b, sx, zx;
        op = int'(w[31:26]); fn = int'(w[5:0]);
        s = int'(w[25:21]); t = int'(w[20:16]); r = int'(w[15:11]);
        a = rd_reg(s); b = rd_reg(t);
        sx = {{16{w[15]}}, w[15:0]};
        zx = {16'd0, w[15:0]};
        d = 32'd0; dst = 5'd0; ill = 1'b0;
        if (v) begin
            ill = 1'b1;
            if (op == 0) begin
                if (fn == 32) begin d = a + b; ill = 1'b0; end
                if (fn == 34) begin d = a - b; ill = 1'b0; end
                if (fn == 42) begin d = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; ill = 1'b0; end
                if (!ill) dst = 5'(r);
            end else begin
                if (op == 8)  begin d = a + sx; ill = 1'b0; end
                if (op == 10) begin d = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; ill = 1'b0; end
                if (op == 12) begin d = a & zx; ill = 1'b0; end
                if (op == 13) begin d = a | zx; ill = 1'b0; end
                if (op == 15) begin d = {w[15:0], 16'd0}; ill = 1'b0; end
                if (!ill) dst = 5'(t);
            end
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input string req);
        logic [31:0] ed;
        logic [4:0]  edst;
        logic        eill;
        @(negedge clk);
        in_valid = v;
        instr    = w;
        predict(v, w, ed, edst, eill);
        #5;
        checks++;
        if (wb_data !== ed || wb_dst !== edst || illegal !== eill) begin
            errors++;
            $display("FAIL %s instr=%08h actual data=%08h dst=%0d ill=%0b expected data=%08h dst=%0d ill=%0b",
                     req, w, wb_data, wb_dst, illegal, ed, edst, eill);
        end
        if (v && !eill && edst != 5'd0) model_regs[edst] = ed;
    endtask

    task automatic peek(int k, input string req);
        step(1'b1, rtype(k, 0, 31, 32), req);
    endtask

    logic done = 1'b0;

    initial begin
        for (int i = 0; i < 32; i++) model_regs[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: idle cycles after reset
        step(1'b0, 32'd0, "R12");
        // R1: every register reads zero after reset
        for (int k = 1; k < 32; k++) step(1'b1, rtype(k, 0, k, 32), "R1");

        // R5: sign-extended add immediate
        step(1'b1, itype(8, 0, 1, 16'h7FFF), "R5");
        step(1'b1, itype(8, 0, 2, 16'hFFCE), "R5");
        // R8 / R7: build a full constant
        step(1'b1, itype(15, 0, 3, 16'hABAB), "R8");
        step(1'b1, itype(13, 3, 3, 16'hCDCD), "R7");
        step(1'b1, itype(12, 3, 4, 16'hF0F0), "R7");
        step(1'b1, itype(13, 2, 5, 16'h8001), "R7");
        // R2 / R3
        step(1'b1, rtype(1, 2, 6, 32), "R2");
        step(1'b1, rtype(2, 1, 7, 34), "R3");
        step(1'b1, rtype(0, 1, 8, 34), "R3");
        // wrap: 0x7FFFFFFF + 1 and doubling
        step(1'b1, itype(15, 0, 9, 16'h7FFF), "R8");
        step(1'b1, itype(13, 9, 9, 16'hFFFF), "R7");
        step(1'b1, itype(8, 9, 10, 1), "R5");
        step(1'b1, rtype(9, 9, 11, 32), "R2");
        step(1'b1, rtype(10, 9, 12, 32), "R2");
        // R4 signed compare
        step(1'b1, rtype(2, 1, 13, 42), "R4");
        step(1'b1, rtype(1, 2, 14, 42), "R4");
        step(1'b1, rtype(10, 0, 15, 42), "R4");
        step(1'b1, rtype(1, 1, 16, 42), "R4");
        // R6 immediate compare
        step(1'b1, itype(10, 2, 17, 16'hFFCF), "R6");
        step(1'b1, itype(10, 1, 18, 16'h8000), "R6");
        step(1'b1, itype(10, 10, 19, 16'h8000), "R6");
        // R9 register zero
        step(1'b1, rtype(1, 1, 0, 32), "R9");
        step(1'b1, itype(15, 0, 0, 16'h1234), "R9");
        step(1'b1, rtype(0, 0, 20, 32), "R9");
        // R10 illegal words leave r1 unchanged
        step(1'b1, itype(63, 2, 1, 16'h0001), "R10");
        step(1'b1, rtype(2, 2, 1, 33), "R10");
        step(1'b1, {6'd0, 5'd2, 5'd2, 5'd1, 5'd0, 6'd0}, "R10");
        peek(1, "R10");
        // R12 idle word that would write r1
        step(1'b0, itype(8, 0, 1, 16'h0055), "R12");
        peek(1, "R12");
        // R11 back-to-back dependency
        step(1'b1, itype(8, 0, 21, 5), "R11");
        step(1'b1, itype(8, 21, 21, 5), "R11");
        step(1'b1, rtype(21, 21, 21, 32), "R11");
        peek(21, "R11");

        // R11: mixed stream
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [31:0] w;
            sel = int'($urandom_range(0, 11));
            case (sel)
                0: w = rtype(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 32);
                1: w = rtype(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 34);
                2: w = rtype(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 42);
                3: w = itype(8,  int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                4: w = itype(10, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                5: w = itype(12, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                6: w = itype(13, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                7: w = itype(15, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
                default: w = $urandom();
            endcase
            step(sel != 11, w, "R11");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule